// File: doc/BRIEF.md
# Wake-on-Receive UART Receiver

This block is an asynchronous serial receive channel that can take in a frame while the host processor sleeps. The host raises `stop_req` to enter a stop mode. While the block is stopped, it watches the serial line. It does this only if wake-on-receive is enabled and the fast internal clock is the selected operating clock. A falling edge on the line moves the block into a snooze mode and raises a clock request to the clock controller. No processor action is needed for this.

In snooze mode the receiver qualifies the start bit and shifts in one 8-bit frame, with or without a parity bit. What happens next depends on the frame:
- A clean frame wakes the host through the receive interrupt and returns the power mode to run.
- With silent-error mode set, a frame with a parity, framing or overrun error is dropped quietly. The data register and flags are left untouched, the clock request falls and the block parks in stop again.
- A low pulse too short to be a start bit starts no transfer. The block stays in snooze with the clock still requested.

In run mode the same receiver works as an ordinary polled or interrupt-driven UART input. It keeps sticky error flags and raises an error interrupt that can be enabled on its own.

Top module: `wake_uart_rx`

## Requirements
- R1: In stop mode (`pwr_mode`=01), when `snz_en`=1 and `hs_clk_sel`=1, a falling edge on `rxd` moves the block to snooze (`pwr_mode`=10) with `clk_req`=1 and starts a reception, with no host input.
- R2: When `snz_en`=0 or `hs_clk_sel`=0, line activity in stop mode is ignored: `pwr_mode` stays 01, `busy` stays 0, and no data or interrupt is produced.
- R3: When `err_silent`=1, a parity, framing or overrun error sets no flag and raises no `err_irq`.
- R4: When `err_silent`=1 and the frame has an error, `rx_data` is unchanged and `rx_irq` stays low. If the frame was taken in snooze, the block returns to stop with `clk_req`=0.
- R5: A start bit is accepted only if the synchronized line is still low at mid-bit, which is `OVS/2` oversample ticks after the edge. A shorter low pulse starts no transfer: `busy` returns to 0, and a block in snooze stays in snooze with `clk_req`=1.
- R6: A frame is one low start bit, then 8 data bits LSB first, then an optional parity bit (`par_en`=1), then a high stop bit. With `par_odd`=0 the data bits plus the parity bit hold an even number of ones; with `par_odd`=1 they hold an odd number. In non-silent mode a parity mismatch sets `flag_parity` and a low stop bit sets `flag_frame`.
- R7: `err_irq` gives a one-cycle pulse for an errored frame only when `err_irq_en`=1 and `err_silent`=0. When `err_irq_en`=0 the flags still set but `err_irq` stays low.
- R8: A frame that is accepted loads `rx_data` and pulses `rx_irq` for one cycle. When the frame was taken in snooze, `pwr_mode` returns to run (00) and `clk_req` falls.
- R9: `busy` is high from start-bit detection through the stop-bit sample, and low otherwise.
- R10: If a frame completes while the previous data is unread (no `rd_ack` since the last load), then with `err_silent`=0 `flag_overrun` sets and the new data replaces the old. With `err_silent`=1 the frame is discarded.
- R11: A rising edge on `stop_req` in run mode enters stop mode. `stop_req`=0 forces run mode from any mode.
- R12: After reset the block is in run mode, with `clk_req`, `busy`, the flags, the interrupts and `rx_data` all 0. A `clr_err` pulse clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample enable, OVS ticks per bit |
| rxd | input | 1 | Serial receive line, idle high |
| stop_req | input | 1 | Host stop request (level) |
| hs_clk_sel | input | 1 | Fast internal clock is the operating clock |
| snz_en | input | 1 | Wake-on-receive enable |
| err_silent | input | 1 | Discard errored frames without flags or interrupts |
| err_irq_en | input | 1 | Error interrupt enable |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| rd_ack | input | 1 | Host has read `rx_data` |
| clr_err | input | 1 | Clear the error flags |
| pwr_mode | output | 2 | 00 run, 01 stop, 10 snooze |
| clk_req | output | 1 | Clock request to the clock controller |
| busy | output | 1 | Transfer in progress |
| rx_data | output | DW | Last accepted data word |
| rx_irq | output | 1 | Receive-complete pulse |
| err_irq | output | 1 | Reception-error pulse |
| flag_parity | output | 1 | Sticky parity error flag |
| flag_frame | output | 1 | Sticky framing error flag |
| flag_overrun | output | 1 | Sticky overrun error flag |

## Verification
The bench builds the block with its defaults: `OVS`=16, `DW`=8, two synchronizer stages, and `os_tick` held high, so one bit lasts sixteen clocks. With an 8-bit word, every one of the 256 data codes can be sent as an even-parity frame and compared with the bench's own arithmetic. The short frame time also leaves room to go through every way into and out of stop, snooze and run. These include each disabled combination of the wake-on-receive conditions, a glitch shorter than half a bit, and silent and reported handling of parity, framing and overrun errors.

// File: rtl/wur_pkg.sv
package wur_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_STOP   = 2'd1,
        PM_SNOOZE = 2'd2
    } pmode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rxst_e;
endpackage

// File: rtl/wur_line_sync.sv
module wur_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], rxd};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh   <= '1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.sh[STAGES-1];
    assign fall_o = q.prev & ~q.sh[STAGES-1];
endmodule

// File: rtl/wur_rx_engine.sv
module wur_rx_engine
    import wur_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          line,
    input  logic          fall,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] MID_C  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);
    localparam logic [IW-1:0] TOP_C  = IW'(DW - 1);

    typedef struct packed {
        rxst_e         st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          par;
        logic          done;
        logic [DW-1:0] data;
        logic          perr;
        logic          ferr;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            RX_IDLE: begin
                if (en && fall) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == MID_C) begin
                        d.cnt = '0;
                        if (!line) begin
                            d.st  = RX_DATA;
                            d.idx = '0;
                            d.par = 1'b0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.cnt == LAST_C) begin
                        d.cnt = '0;
                        d.sh  = {line, q.sh[DW-1:1]};
                        d.par = q.par ^ line;
                        if (q.idx == TOP_C) begin
                            d.st = par_en ? RX_PAR : RX_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_PAR: begin
                if (tick) begin
                    if (q.cnt == LAST_C) begin
                        d.cnt = '0;
                        d.par = q.par ^ line;
                        d.st  = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (q.cnt == LAST_C) begin
                        d.cnt  = '0;
                        d.st   = RX_IDLE;
                        d.done = 1'b1;
                        d.data = q.sh;
                        d.perr = par_en & (q.par ^ par_odd);
                        d.ferr = ~line;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= RX_IDLE;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.sh   <= '0;
            q.par  <= 1'b0;
            q.done <= 1'b0;
            q.data <= '0;
            q.perr <= 1'b0;
            q.ferr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != RX_IDLE);
    assign done = q.done;
    assign data = q.data;
    assign perr = q.perr;
    assign ferr = q.ferr;
endmodule

// File: rtl/wur_result.sv
module wur_result #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] data,
    input  logic          perr,
    input  logic          ferr,
    input  logic          silent,
    input  logic          eirq_en,
    input  logic          rd_ack,
    input  logic          clr_err,
    output logic [DW-1:0] rx_data,
    output logic          f_par,
    output logic          f_frm,
    output logic          f_ovr,
    output logic          rx_irq,
    output logic          err_irq,
    output logic          wake_evt,
    output logic          drop_evt
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          fpar;
        logic          ffrm;
        logic          fovr;
        logic          rxirq;
        logic          eirq;
    } res_t;

    res_t q, d;
    logic ovr, anyerr;

    always_comb begin
        ovr      = q.full & ~rd_ack;
        anyerr   = perr | ferr | ovr;
        wake_evt = done & ~(silent & anyerr);
        drop_evt = done & silent & anyerr;

        d       = q;
        d.rxirq = 1'b0;
        d.eirq  = 1'b0;
        if (rd_ack) d.full = 1'b0;
        if (clr_err) begin
            d.fpar = 1'b0;
            d.ffrm = 1'b0;
            d.fovr = 1'b0;
        end
        if (wake_evt) begin
            d.data  = data;
            d.full  = 1'b1;
            d.rxirq = 1'b1;
            if (perr) d.fpar = 1'b1;
            if (ferr) d.ffrm = 1'b1;
            if (ovr)  d.fovr = 1'b1;
            d.eirq  = eirq_en & anyerr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_data = q.data;
    assign f_par   = q.fpar;
    assign f_frm   = q.ffrm;
    assign f_ovr   = q.fovr;
    assign rx_irq  = q.rxirq;
    assign err_irq = q.eirq;
endmodule

// File: rtl/wur_pwr_ctl.sv
module wur_pwr_ctl
    import wur_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stop_req,
    input  logic   fall,
    input  logic   snz_ok,
    input  logic   wake_evt,
    input  logic   drop_evt,
    output pmode_e mode,
    output logic   clk_req,
    output logic   rx_en
);
    typedef struct packed {
        pmode_e mode;
        logic   stop_prev;
    } pwr_t;

    pwr_t q, d;

    always_comb begin
        d           = q;
        d.stop_prev = stop_req;
        if (!stop_req) begin
            d.mode = PM_RUN;
        end else begin
            unique case (q.mode)
                PM_RUN:    if (!q.stop_prev) d.mode = PM_STOP;
                PM_STOP:   if (fall && snz_ok) d.mode = PM_SNOOZE;
                PM_SNOOZE: begin
                    if (wake_evt)      d.mode = PM_RUN;
                    else if (drop_evt) d.mode = PM_STOP;
                end
                default:   d.mode = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode      <= PM_RUN;
            q.stop_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mode    = q.mode;
    assign clk_req = (q.mode == PM_SNOOZE);
    assign rx_en   = (q.mode != PM_STOP) | snz_ok;
endmodule

// File: rtl/wake_uart_rx.sv
module wake_uart_rx
    import wur_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic          stop_req,
    input  logic          hs_clk_sel,
    input  logic          snz_en,
    input  logic          err_silent,
    input  logic          err_irq_en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          rd_ack,
    input  logic          clr_err,
    output logic [1:0]    pwr_mode,
    output logic          clk_req,
    output logic          busy,
    output logic [DW-1:0] rx_data,
    output logic          rx_irq,
    output logic          err_irq,
    output logic          flag_parity,
    output logic          flag_frame,
    output logic          flag_overrun
);
    logic          line, fall, rx_en, snz_ok;
    logic          done, perr, ferr, wake_evt, drop_evt;
    logic [DW-1:0] fr_data;
    pmode_e        mode;

    assign snz_ok = snz_en & hs_clk_sel;

    wur_line_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .line_o(line), .fall_o(fall)
    );

    wur_rx_engine #(.OVS(OVS), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(rx_en),
        .line(line), .fall(fall), .par_en(par_en), .par_odd(par_odd),
        .busy(busy), .done(done), .data(fr_data), .perr(perr), .ferr(ferr)
    );

    wur_result #(.DW(DW)) u_res (
        .clk(clk), .rst_n(rst_n), .done(done), .data(fr_data),
        .perr(perr), .ferr(ferr), .silent(err_silent), .eirq_en(err_irq_en),
        .rd_ack(rd_ack), .clr_err(clr_err), .rx_data(rx_data),
        .f_par(flag_parity), .f_frm(flag_frame), .f_ovr(flag_overrun),
        .rx_irq(rx_irq), .err_irq(err_irq),
        .wake_evt(wake_evt), .drop_evt(drop_evt)
    );

    wur_pwr_ctl u_pwr (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .fall(fall),
        .snz_ok(snz_ok), .wake_evt(wake_evt), .drop_evt(drop_evt),
        .mode(mode), .clk_req(clk_req), .rx_en(rx_en)
    );

    assign pwr_mode = mode;
endmodule

// File: rtl/wake_uart_rx_chk.sv
module wake_uart_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_req,
    input logic          snz_en,
    input logic          hs_clk_sel,
    input logic          err_silent,
    input logic          err_irq_en,
    input logic [1:0]    pwr_mode,
    input logic          busy,
    input logic [DW-1:0] rx_data,
    input logic          rx_irq,
    input logic          err_irq,
    input logic          flag_parity,
    input logic          flag_frame,
    input logic          flag_overrun
);
    AST_NO_WAKE_WHEN_BARRED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd1 && stop_req && !(snz_en && hs_clk_sel)) |=> (pwr_mode != 2'd2)); // R2

    AST_STOP_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd1 && stop_req && !busy) |=> (!busy || pwr_mode == 2'd2)); // R9

    AST_SILENT_NO_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_silent |=> !err_irq); // R3

    AST_SILENT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_silent && !flag_parity && !flag_frame && !flag_overrun)
        |=> (!flag_parity && !flag_frame && !flag_overrun)); // R3

    AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !err_irq_en |=> !err_irq); // R7

    AST_ERR_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (flag_parity || flag_frame || flag_overrun)); // R7

    AST_WAKE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && $past(pwr_mode) == 2'd2 && $past(stop_req)) |-> (pwr_mode == 2'd0)); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq |-> $stable(rx_data)); // R4
endmodule

bind wake_uart_rx wake_uart_rx_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .snz_en(snz_en),
    .hs_clk_sel(hs_clk_sel), .err_silent(err_silent), .err_irq_en(err_irq_en),
    .pwr_mode(pwr_mode), .busy(busy), .rx_data(rx_data), .rx_irq(rx_irq),
    .err_irq(err_irq), .flag_parity(flag_parity), .flag_frame(flag_frame),
    .flag_overrun(flag_overrun)
);

// File: tb/wake_uart_rx_test.sv
module wake_uart_rx_test;
    localparam int OVS = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic os_tick = 1'b1, rxd = 1'b1, stop_req = 1'b0, hs_clk_sel = 1'b1;
    logic snz_en = 1'b0, err_silent = 1'b0, err_irq_en = 1'b1;
    logic par_en = 1'b1, par_odd = 1'b0, rd_ack = 1'b0, clr_err = 1'b0;
    logic [1:0] pwr_mode;
    logic clk_req, busy, rx_irq, err_irq, flag_parity, flag_frame, flag_overrun;
    logic [7:0] rx_data;

    int n_chk = 0, n_err = 0, n_rx = 0, n_ei = 0, cyc = 0;
    logic [1:0] mid_mode;
    logic mid_busy, mid_clk;

    wake_uart_rx uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .stop_req(stop_req),
        .hs_clk_sel(hs_clk_sel), .snz_en(snz_en), .err_silent(err_silent),
        .err_irq_en(err_irq_en), .par_en(par_en), .par_odd(par_odd), .rd_ack(rd_ack),
        .clr_err(clr_err), .pwr_mode(pwr_mode), .clk_req(clk_req), .busy(busy),
        .rx_data(rx_data), .rx_irq(rx_irq), .err_irq(err_irq), .flag_parity(flag_parity),
        .flag_frame(flag_frame), .flag_overrun(flag_overrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && rx_irq)  n_rx <= n_rx + 1;
        if (rst_n && err_irq) n_ei <= n_ei + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] dv, input bit pe, input bit po,
                        input bit bad_par, input bit bad_stop);
        logic p;
        p = ^dv ^ po;
        if (bad_par) p = ~p;
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) begin
            bit_time(dv[i]);
            if (i == 3) begin
                mid_mode = pwr_mode;
                mid_busy = busy;
                mid_clk  = clk_req;
            end
        end
        if (pe) bit_time(p);
        bit_time(!bad_stop);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic pulse_rd;
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr;
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
    endtask

    task automatic set_stop(input logic v);
        stop_req = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic int flags();
        return {flag_parity, flag_frame, flag_overrun};
    endfunction

    initial begin : watchdog
        wait (cyc >= 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int r0, e0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 mode", pwr_mode, 0);
        chk("R12 clk_req", clk_req, 0);
        chk("R12 busy", busy, 0);
        chk("R12 flags", flags(), 0);
        chk("R12 data", rx_data, 0);

        // R6 / R8 / R9 sweep of every data code, even parity, run mode
        for (int v = 0; v < 256; v++) begin
            r0 = n_rx;
            send(8'(v), 1, 0, 0, 0);
            chk("R6 data", rx_data, v);
            chk("R8 rx_irq", n_rx, r0 + 1);
            chk("R6 no flags", flags(), 0);
            chk("R9 busy mid", mid_busy, 1);
            chk("R9 busy idle", busy, 0);
            pulse_rd();
        end

        // R6 odd parity, good frames
        par_odd = 1'b1;
        for (int v = 0; v < 16; v++) begin
            send(8'(v * 17 + 3), 1, 1, 0, 0);
            chk("R6 odd data", rx_data, (v * 17 + 3) & 255);
            chk("R6 odd flags", flags(), 0);
            pulse_rd();
        end
        // R6 / R7 parity error reported
        e0 = n_ei;
        send(8'h6C, 1, 1, 1, 0);
        chk("R6 parity flag", flags(), 3'b100);
        chk("R7 err_irq", n_ei, e0 + 1);
        pulse_clr();
        chk("R12 clear", flags(), 0);
        pulse_rd();
        // R6 no parity bit
        par_en = 1'b0;
        send(8'hB7, 0, 0, 0, 0);
        chk("R6 no parity data", rx_data, 8'hB7);
        chk("R6 no parity flags", flags(), 0);
        pulse_rd();
        par_en = 1'b1; par_odd = 1'b0;

        // R6 framing error
        e0 = n_ei;
        send(8'h3C, 1, 0, 0, 1);
        chk("R6 frame flag", flags(), 3'b010);
        chk("R7 frame err_irq", n_ei, e0 + 1);
        pulse_clr(); pulse_rd();

        // R10 overrun, non-silent
        send(8'h11, 1, 0, 0, 0);
        send(8'h22, 1, 0, 0, 0);
        chk("R10 overrun flag", flags(), 3'b001);
        chk("R10 data replaced", rx_data, 8'h22);
        pulse_clr(); pulse_rd();

        // R7 error interrupt disabled
        err_irq_en = 1'b0;
        e0 = n_ei;
        send(8'h90, 1, 0, 1, 0);
        chk("R7 flag without irq", flags(), 3'b100);
        chk("R7 no err_irq", n_ei, e0);
        pulse_clr(); pulse_rd();
        err_irq_en = 1'b1;

        // R11 / R1 / R8 snooze wake on good frame
        snz_en = 1'b1;
        set_stop(1'b1);
        chk("R11 enter stop", pwr_mode, 1);
        chk("R11 no clk_req", clk_req, 0);
        r0 = n_rx;
        send(8'h5A, 1, 0, 0, 0);
        chk("R1 snooze mid", mid_mode, 2);
        chk("R1 clk_req mid", mid_clk, 1);
        chk("R9 busy snooze", mid_busy, 1);
        chk("R8 woke to run", pwr_mode, 0);
        chk("R8 clk_req low", clk_req, 0);
        chk("R8 data", rx_data, 8'h5A);
        chk("R8 irq", n_rx, r0 + 1);
        set_stop(1'b0);
        pulse_rd();

        // R2 each barred combination
        for (int c = 0; c < 3; c++) begin
            snz_en = c[0];
            hs_clk_sel = c[1];
            set_stop(1'b1);
            r0 = n_rx;
            send(8'h33, 1, 0, 0, 0);
            chk("R2 busy stays low", mid_busy, 0);
            chk("R2 stays stop", pwr_mode, 1);
            chk("R2 no irq", n_rx, r0);
            chk("R2 data kept", rx_data, 8'h5A);
            set_stop(1'b0);
            chk("R11 leave stop", pwr_mode, 0);
        end
        snz_en = 1'b1; hs_clk_sel = 1'b1;

        // R5 short pulse keeps snooze
        set_stop(1'b1);
        r0 = n_rx;
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (40) @(negedge clk);
        chk("R5 parked snooze", pwr_mode, 2);
        chk("R5 clk_req held", clk_req, 1);
        chk("R5 no transfer", busy, 0);
        chk("R5 no irq", n_rx, r0);
        send(8'h81, 1, 0, 0, 0);
        chk("R5 next frame wakes", pwr_mode, 0);
        chk("R5 next data", rx_data, 8'h81);
        set_stop(1'b0);
        pulse_rd();

        // R3 / R4 silent discard in snooze
        err_silent = 1'b1;
        set_stop(1'b1);
        r0 = n_rx; e0 = n_ei;
        send(8'h77, 1, 0, 1, 0);
        chk("R4 back to stop", pwr_mode, 1);
        chk("R4 clk_req low", clk_req, 0);
        chk("R3 parity silent", flags(), 0);
        chk("R3 no err_irq", n_ei, e0);
        chk("R4 no rx_irq", n_rx, r0);
        chk("R4 data kept", rx_data, 8'h81);
        send(8'h66, 1, 0, 0, 1);
        chk("R3 frame silent", flags(), 0);
        chk("R4 stop again", pwr_mode, 1);
        chk("R4 data kept 2", rx_data, 8'h81);
        send(8'h42, 1, 0, 0, 0);
        chk("R8 silent good wakes", pwr_mode, 0);
        chk("R8 silent good data", rx_data, 8'h42);
        set_stop(1'b0);
        // R10 overrun under silent is discarded
        r0 = n_rx;
        send(8'h99, 1, 0, 0, 0);
        chk("R10 silent discard", rx_data, 8'h42);
        chk("R10 silent no flag", flags(), 0);
        chk("R10 silent no irq", n_rx, r0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule